// File: doc/BRIEF.md
# Memory-Mapped Interrupt Aggregation Controller

This block sits on a host processor's 16-bit address and 8-bit data bus. It gives the host three interrupt outputs, all active low. The first is a non-maskable line that follows a power-fail source. The second is a fast-interrupt line held by a latch: a periodic tick sets the latch, and any qualified bus access to one fixed address clears it. The third is a general interrupt line that merges five request sources. The host can mask three of those sources through a writable register. A second bus master can hold back the display-done source on its own, through a separate gate input.

The block decodes an I/O window that is qualified by the valid-address strobe. Inside that window, eight consecutive addresses each get an active-low enable. The host reads the gated request lines and three system status bits at the first of those addresses. It reads the mask back at the second. It clears the fast-interrupt latch with any access to the third. A two-bit level output reports the highest-priority interrupt pending, so that service can begin with that one.

Top module: `irqw_ctrl`

## Requirements
- R1: `sel_n[k]` is low exactly when `bus_vma` is high, `bus_rd` or `bus_wr` is high, and `bus_addr` equals 6010h+k for k = 0..7. All enables stay high for any other address, including 7010h, 6018h, and 6010h while `bus_vma` is low.
- R2: A qualified read of 6010h returns status in this layout: bits 0..4 are the gated requests (bit 0 instrument bus, bit 1 display-done after the second master's gate, bit 2 front panel, bit 3 waveform processor, bit 4 trigger, with bits 2..4 after the host mask), bit 5 the front-panel read handshake, bit 6 power-good, bit 7 bus-grant.
- R3: The host mask lives at 6011h. Bit 0 enables the front panel, bit 1 the waveform processor, bit 2 the trigger. A write stores `bus_wdata[2:0]`, which takes effect from the next cycle. A read returns the mask in bits 2..0 and zeros above it. Reset clears the mask.
- R4: `irq_n` is low exactly when at least one gated request (R2 bits 0..4) is active. A mask bit of 0 blocks its source. The instrument-bus source cannot be masked.
- R5: With `disp_gate` low, the display-done request never reaches `irq_n` or status bit 1. With `disp_gate` high, a pending display-done request appears at once.
- R6: A `tick_2ms` pulse sets the fast-interrupt latch, and `firq_n` is low from the next cycle on. Reset clears the latch.
- R7: A qualified read or write of 6012h clears the latch in the next cycle. When a tick arrives in the same cycle as the clear, the latch stays set. With neither, the latch holds its value.
- R8: `nmi_n` is the inverse of `nmi_src` in the same cycle.
- R9: `int_level` is 3 when NMI is pending, otherwise 2 when the fast interrupt is pending, otherwise 1 when IRQ is pending, otherwise 0.
- R10: `bus_oe` is high only during a qualified read of 6010h or 6011h. `bus_rdata` is zero whenever `bus_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Host address |
| bus_vma | input | 1 | Valid memory address strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| bus_oe | output | 1 | Read data drive enable |
| sel_n | output | 8 | Decoded register enables, active low |
| src_req | input | 5 | Raw requests: instrument bus, display-done, front panel, waveform, trigger |
| disp_gate | input | 1 | Display-done pass gate driven by the second master |
| tick_2ms | input | 1 | Periodic tick pulse |
| nmi_src | input | 1 | Power-fail request, active high |
| pwr_ok | input | 1 | Power-good status |
| bus_grant | input | 1 | Bus released by the second master |
| fp_read_done | input | 1 | Front-panel processor has read its data |
| irq_n | output | 1 | General interrupt, active low |
| firq_n | output | 1 | Fast interrupt, active low |
| nmi_n | output | 1 | Non-maskable interrupt, active low |
| int_level | output | 2 | Highest pending level (0 none, 1 IRQ, 2 FIRQ, 3 NMI) |

## Verification
The clocked assertions rely on all inputs being stable around the rising edge. They also assume a tick and a clear access each last a single cycle as seen at that edge. The bench meets both assumptions by changing every input just after the falling edge. The bus checks assume that a write of 6011h and a clear at 6012h are never mixed within one access. Since an address selects one register, random stimulus cannot break this. The stimulus is biased toward 6010h..6017h and also covers the window's edges, addresses outside the window, and accesses without the strobe. Reset is asserted once more in the middle of the run.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
   typedef enum logic [1:0] {
      LVL_NONE = 2'd0,
      LVL_IRQ  = 2'd1,
      LVL_FIRQ = 2'd2,
      LVL_NMI  = 2'd3
   } irq_level_e;

   localparam int OFS_STATUS = 0;
   localparam int OFS_MASK   = 1;
   localparam int OFS_CLEAR  = 2;
   localparam int NUM_EXTRA  = 3;
endpackage

// File: rtl/irqw_decode.sv
module irqw_decode #(
   parameter int ADDR_W   = 16,
   parameter int TOP_BITS = 3,
   parameter logic [TOP_BITS-1:0] TOP_TAG = 3'b011,
   parameter int SEL_N    = 8,
   parameter logic [ADDR_W-1:0] REG_BASE = 16'h6010
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              vma,
   input  logic              strobe,
   output logic              blk_hit,
   output logic [SEL_N-1:0]  sel_n
);
   localparam int SEL_W = $clog2(SEL_N);
   localparam int NB_BIT = ADDR_W - TOP_BITS - 1;

   if (SEL_N < 2 || (1 << SEL_W) != SEL_N) begin : g_bad_sel
      $error("SEL_N must be a power of two");
   end
   if (REG_BASE[ADDR_W-1 -: TOP_BITS] != TOP_TAG || REG_BASE[NB_BIT]) begin : g_bad_base
      $error("REG_BASE lies outside the decoded window");
   end

   logic win_hit;

   always_comb begin
      win_hit = vma && (addr[ADDR_W-1 -: TOP_BITS] == TOP_TAG) && !addr[NB_BIT];
      blk_hit = win_hit && (addr[ADDR_W-1:SEL_W] == REG_BASE[ADDR_W-1:SEL_W]);
   end

   for (genvar k = 0; k < SEL_N; k++) begin : g_sel
      assign sel_n[k] = !(blk_hit && strobe && (addr[SEL_W-1:0] == SEL_W'(k)));
   end
endmodule

// File: rtl/irqw_gate.sv
module irqw_gate #(
   parameter int NUM_SRC  = 5,
   parameter int MASK_LO  = 2,
   parameter int NUM_MASK = 3,
   parameter int DISP_IDX = 1
) (
   input  logic [NUM_SRC-1:0]  req,
   input  logic [NUM_MASK-1:0] mask,
   input  logic                disp_gate,
   output logic [NUM_SRC-1:0]  gated,
   output logic                any_req
);
   if (MASK_LO + NUM_MASK > NUM_SRC) begin : g_bad_mask
      $error("mask range exceeds source count");
   end
   if (DISP_IDX >= MASK_LO && DISP_IDX < MASK_LO + NUM_MASK) begin : g_bad_disp
      $error("display source must not be host-maskable");
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i >= MASK_LO && i < MASK_LO + NUM_MASK) begin : g_host_mask
         assign gated[i] = req[i] && mask[i - MASK_LO];
      end else if (i == DISP_IDX) begin : g_peer_mask
         assign gated[i] = req[i] && disp_gate;
      end else begin : g_open
         assign gated[i] = req[i];
      end
   end

   assign any_req = |gated;
endmodule

// File: rtl/irqw_firq.sv
module irqw_firq #(
   parameter bit TICK_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clr,
   output logic q
);
   if (TICK_WINS) begin : g_tick_first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    q <= 1'b0;
         else if (tick) q <= 1'b1;
         else if (clr)  q <= 1'b0;
      end

      assert_tick_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> q);
      assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && !tick) |=> !q);
   end else begin : g_clear_first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    q <= 1'b0;
         else if (clr)  q <= 1'b0;
         else if (tick) q <= 1'b1;
      end

      assert_tick_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && !clr) |=> q);
      assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> !q);
   end

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> (q == $past(q)));
endmodule

// File: rtl/irqw_ctrl.sv
module irqw_ctrl
   import irqw_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int SEL_N    = 8,
   parameter int NUM_SRC  = 5,
   parameter int MASK_LO  = 2,
   parameter int NUM_MASK = 3,
   parameter int DISP_IDX = 1,
   parameter logic [ADDR_W-1:0] REG_BASE = 16'h6010,
   parameter bit TICK_WINS = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_vma,
   input  logic                bus_rd,
   input  logic                bus_wr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                bus_oe,
   output logic [SEL_N-1:0]    sel_n,
   input  logic [NUM_SRC-1:0]  src_req,
   input  logic                disp_gate,
   input  logic                tick_2ms,
   input  logic                nmi_src,
   input  logic                pwr_ok,
   input  logic                bus_grant,
   input  logic                fp_read_done,
   output logic                irq_n,
   output logic                firq_n,
   output logic                nmi_n,
   output logic [1:0]          int_level
);
   localparam int SEL_W = $clog2(SEL_N);

   if (NUM_SRC + NUM_EXTRA > DATA_W) begin : g_bad_width
      $error("status does not fit the data bus");
   end
   if (NUM_MASK > DATA_W) begin : g_bad_mask_w
      $error("mask does not fit the data bus");
   end
   if (SEL_N <= OFS_CLEAR) begin : g_bad_count
      $error("too few decoded enables");
   end

   logic                blk_hit;
   logic                strobe;
   logic [NUM_SRC-1:0]  gated;
   logic                irq_any;
   logic [NUM_MASK-1:0] mask_q;
   logic                mask_we;
   logic                firq_clr;
   logic                firq_q;
   logic                rd_status;
   logic                rd_mask;
   logic [DATA_W-1:0]   status_word;
   irq_level_e          lvl;

   assign strobe = bus_rd || bus_wr;

   irqw_decode #(
      .ADDR_W   (ADDR_W),
      .TOP_BITS (3),
      .TOP_TAG  (3'b011),
      .SEL_N    (SEL_N),
      .REG_BASE (REG_BASE)
   ) u_dec (
      .addr    (bus_addr),
      .vma     (bus_vma),
      .strobe  (strobe),
      .blk_hit (blk_hit),
      .sel_n   (sel_n)
   );

   assign mask_we   = !sel_n[OFS_MASK] && bus_wr;
   assign firq_clr  = !sel_n[OFS_CLEAR];
   assign rd_status = !sel_n[OFS_STATUS] && bus_rd;
   assign rd_mask   = !sel_n[OFS_MASK] && bus_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= bus_wdata[NUM_MASK-1:0];
   end

   irqw_gate #(
      .NUM_SRC  (NUM_SRC),
      .MASK_LO  (MASK_LO),
      .NUM_MASK (NUM_MASK),
      .DISP_IDX (DISP_IDX)
   ) u_gate (
      .req       (src_req),
      .mask      (mask_q),
      .disp_gate (disp_gate),
      .gated     (gated),
      .any_req   (irq_any)
   );

   irqw_firq #(.TICK_WINS(TICK_WINS)) u_firq (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_2ms),
      .clr   (firq_clr),
      .q     (firq_q)
   );

   always_comb begin
      status_word = '0;
      status_word[NUM_SRC-1:0] = gated;
      status_word[DATA_W-3]    = fp_read_done;
      status_word[DATA_W-2]    = pwr_ok;
      status_word[DATA_W-1]    = bus_grant;
   end

   always_comb begin
      bus_oe    = rd_status || rd_mask;
      bus_rdata = '0;
      if (rd_status)    bus_rdata = status_word;
      else if (rd_mask) bus_rdata[NUM_MASK-1:0] = mask_q;
   end

   always_comb begin
      if (nmi_src)      lvl = LVL_NMI;
      else if (firq_q)  lvl = LVL_FIRQ;
      else if (irq_any) lvl = LVL_IRQ;
      else              lvl = LVL_NONE;
   end

   assign int_level = lvl;
   assign irq_n     = !irq_any;
   assign firq_n    = !firq_q;
   assign nmi_n     = !nmi_src;

   assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~sel_n));
   assert_sel_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n != '1) |-> (bus_vma && strobe && blk_hit));
   assert_oe_read_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> (bus_vma && bus_rd && bus_addr[ADDR_W-1:SEL_W] == REG_BASE[ADDR_W-1:SEL_W]));
   assert_mask_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> (mask_q == $past(bus_wdata[NUM_MASK-1:0])));
   assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask_q));
   assert_nmi_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !nmi_n |-> (int_level == LVL_NMI));
   assert_irq_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0 && !src_req[0] && !disp_gate) |-> irq_n);
   assert_disp_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_gate |-> !status_word[DISP_IDX]);
endmodule

// File: tb/irqw_ctrl_test.sv
`timescale 1ns/1ps
module irqw_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_vma = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        bus_oe;
   logic [7:0]  sel_n;
   logic [4:0]  src_req = '0;
   logic        disp_gate = 1'b0, tick_2ms = 1'b0, nmi_src = 1'b0;
   logic        pwr_ok = 1'b0, bus_grant = 1'b0, fp_read_done = 1'b0;
   logic        irq_n, firq_n, nmi_n;
   logic [1:0]  int_level;

   int checks = 0;
   int fails  = 0;
   int m_mask = 0;
   bit m_firq = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   irqw_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_vma(bus_vma),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_oe(bus_oe), .sel_n(sel_n),
      .src_req(src_req), .disp_gate(disp_gate), .tick_2ms(tick_2ms),
      .nmi_src(nmi_src), .pwr_ok(pwr_ok), .bus_grant(bus_grant),
      .fp_read_done(fp_read_done), .irq_n(irq_n), .firq_n(firq_n),
      .nmi_n(nmi_n), .int_level(int_level)
   );

   // behavioural reference state, updated on the same edges as the design
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mask = 0;
         m_firq = 0;
      end else begin
         bit clr_acc;
         clr_acc = bus_vma && (bus_rd || bus_wr) && bus_addr == 16'h6012;
         if (tick_2ms)     m_firq = 1;
         else if (clr_acc) m_firq = 0;
         if (bus_vma && bus_wr && bus_addr == 16'h6011) m_mask = bus_wdata & 7;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int g, irq, lvl, sel, oe, rd;
      g = 0;
      if (src_req[0]) g |= 1;
      if (src_req[1] && disp_gate) g |= 2;
      if (src_req[2] && m_mask[0]) g |= 4;
      if (src_req[3] && m_mask[1]) g |= 8;
      if (src_req[4] && m_mask[2]) g |= 16;
      irq = (g != 0);
      if (nmi_src)     lvl = 3;
      else if (m_firq) lvl = 2;
      else if (irq)    lvl = 1;
      else             lvl = 0;
      sel = 8'hFF;
      for (int k = 0; k < 8; k++)
         if (bus_vma && (bus_rd || bus_wr) && bus_addr == 16'h6010 + k) sel &= ~(1 << k);
      oe = bus_vma && bus_rd && (bus_addr == 16'h6010 || bus_addr == 16'h6011);
      rd = 0;
      if (oe && bus_addr == 16'h6010)
         rd = g | (int'(fp_read_done) << 5) | (int'(pwr_ok) << 6) | (int'(bus_grant) << 7);
      else if (oe) rd = m_mask;
      chk("R1 sel_n", int'(sel_n), sel);
      chk("R4 R5 irq_n", int'(irq_n), !irq);
      chk("R6 R7 firq_n", int'(firq_n), !m_firq);
      chk("R8 nmi_n", int'(nmi_n), !nmi_src);
      chk("R9 int_level", int'(int_level), lvl);
      chk("R10 bus_oe", int'(bus_oe), oe);
      if (bus_addr == 16'h6011) chk("R3 mask readback", int'(bus_rdata), rd);
      else                      chk("R2 R10 rdata", int'(bus_rdata), rd);
   endtask

   task automatic cyc();
      @(negedge clk);
      compare_all();
   endtask

   task automatic bus(logic [15:0] a, bit v, bit r, bit w, logic [7:0] d);
      bus_addr = a; bus_vma = v; bus_rd = r; bus_wr = w; bus_wdata = d;
   endtask

   task automatic idle();
      bus(16'h0000, 0, 0, 0, 8'h00);
      tick_2ms = 0;
   endtask

   initial begin
      // reset state
      cyc(); cyc();
      rst_n = 1'b1;
      // R3 mask resets to zero
      bus(16'h6011, 1, 1, 0, 8'h00); cyc();
      // R4 R5: all sources on, nothing unmasked but the bus source
      src_req = 5'b11111; bus(16'h6010, 1, 1, 0, 8'h00); cyc();
      src_req = 5'b11110; cyc();
      disp_gate = 1; cyc();
      disp_gate = 0; pwr_ok = 1; bus_grant = 1; fp_read_done = 1; cyc();
      // R3 write mask then read it
      bus(16'h6011, 1, 0, 1, 8'hFD); cyc();
      bus(16'h6011, 1, 1, 0, 8'h00); cyc();
      bus(16'h6010, 1, 1, 0, 8'h00); cyc();
      // R6 tick sets latch
      idle(); tick_2ms = 1; cyc();
      tick_2ms = 0; cyc();
      // R7 clear by write, then by read, then tick wins over clear
      bus(16'h6012, 1, 0, 1, 8'h00); cyc();
      idle(); tick_2ms = 1; cyc();
      tick_2ms = 0; bus(16'h6012, 1, 1, 0, 8'h00); cyc();
      idle(); tick_2ms = 1; cyc();
      bus(16'h6012, 1, 0, 1, 8'h00); tick_2ms = 1; cyc();
      idle(); cyc();
      // R7 clear without strobe qualification is ignored
      bus(16'h6012, 0, 0, 1, 8'h00); cyc();
      bus(16'h7012, 1, 0, 1, 8'h00); cyc();
      // R9 NMI over pending FIRQ and IRQ
      nmi_src = 1; idle(); cyc();
      nmi_src = 0; cyc();
      // R1 R10 out-of-window and unqualified accesses
      bus(16'h7010, 1, 1, 0, 8'h00); cyc();
      bus(16'h6010, 0, 1, 0, 8'h00); cyc();
      bus(16'h6018, 1, 1, 0, 8'h00); cyc();
      bus(16'h6017, 1, 0, 1, 8'h00); cyc();
      bus(16'h6000, 1, 1, 0, 8'h00); cyc();
      // R3 write outside the mask address leaves mask unchanged
      bus(16'h7011, 1, 0, 1, 8'h00); cyc();
      bus(16'h6011, 1, 1, 0, 8'h00); cyc();
      // random phase with one mid-run reset
      for (int n = 0; n < 4000; n++) begin
         int pick;
         pick = $urandom % 8;
         if (pick < 5)       bus_addr = 16'h6010 + ($urandom % 8);
         else if (pick == 5) bus_addr = 16'h7010 + ($urandom % 8);
         else if (pick == 6) bus_addr = 16'($urandom);
         else                bus_addr = 16'h6000 | 16'($urandom & 16'h1FFF);
         bus_vma = ($urandom % 4) != 0;
         bus_rd = $urandom % 2;
         bus_wr = ($urandom % 3) == 0;
         bus_wdata = 8'($urandom);
         src_req = 5'($urandom);
         disp_gate = $urandom % 2;
         tick_2ms = ($urandom % 8) == 0;
         nmi_src = ($urandom % 16) == 0;
         pwr_ok = $urandom % 2;
         bus_grant = $urandom % 2;
         fp_read_done = $urandom % 2;
         rst_n = (n != 2000);
         cyc();
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule